// File: doc/BRIEF.md
# Shared-RAM Per-Channel Gamma Correction

This block corrects the colour of RGB pixels on several output channels. All channels share one table RAM. The RAM is divided into one region per channel, and each region holds three 256-entry planes in the order red, green, blue. A pixel that enters with a channel number is replaced, component by component, with the table entries indexed by its red, green and blue values. This happens only when that channel's gamma enable is set. When the enable is clear, the pixel leaves unchanged after the same delay.

A host loads the table through a two-register port. A write to the address register sets the table pointer and an auto-advance flag. Each write to the data register stores one 8-bit entry at the pointer. When the flag is set, the pointer then moves on by one.

The RAM is powered only while at least one channel has gamma enabled. If every enable is clear at the same time, the RAM is off: all stored entries are forgotten and host data writes are dropped. Entries that have not been rewritten since then read as zero.

Top module: `gamma_lut_bank`

## Requirements
- R1: The entry used for channel c, plane p (0 red, 1 green, 2 blue) and component value v sits at table address c*768 + p*256 + v. With gam_en[c] set, each output component equals that entry.
- R2: A host write with host_is_data=0 loads the table pointer from host_wdata[11:0] and the auto-advance flag from host_wdata[12]. The new pointer appears on tbl_addr on the next cycle.
- R3: A data write (host_is_data=1) with the flag set stores host_wdata[7:0] at the pointer and then advances the pointer by one. The pointer wraps from 2303 to 0.
- R4: With the flag clear, a data write leaves the pointer unchanged, so repeated data writes overwrite the same entry.
- R5: When gam_en[c] is clear, a pixel on channel c leaves with its red, green and blue values unchanged.
- R6: out_vld is pix_vld delayed by exactly one cycle, for both the corrected path and the pass-through path.
- R7: Once all gam_en bits have been clear for a cycle, every entry reads as zero until it is written again.
- R8: While all gam_en bits are clear, data writes do not store anything. The pointer still advances when the flag is set.
- R9: A pixel with a channel number of 3 or above passes through unchanged, whatever gam_en holds.
- R10: After reset, out_vld is 0, tbl_addr is 0, the flag is clear, and every table entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_is_data | input | 1 | 1 selects the data register, 0 selects the address register |
| host_wdata | input | 13 | Write data: pointer in [11:0] and flag in [12], or entry in [7:0] |
| tbl_addr | output | 12 | Current table pointer |
| gam_en | input | 3 | Per-channel gamma enable |
| pix_vld | input | 1 | Input pixel valid |
| pix_chan | input | 2 | Channel of the input pixel |
| pix_r | input | 8 | Input red |
| pix_g | input | 8 | Input green |
| pix_b | input | 8 | Input blue |
| out_vld | output | 1 | Output pixel valid |
| out_r | output | 8 | Output red |
| out_g | output | 8 | Output green |
| out_b | output | 8 | Output blue |

## Verification
The hardest situation to reach is a stale table after a power-down. The bench first fills all 2304 entries through the auto-advancing port and checks every channel and plane against an arithmetic pattern. It then clears all three enables for one cycle, pushes host writes into the RAM while it is off, and enables gamma again. After that, the pixels must return zeros for every entry that was not reloaded, while the pointer shows that the dropped writes still advanced it.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
   // Colour planes inside one channel region, in table order
   typedef enum logic [1:0] {
      PL_RED = 2'd0,
      PL_GRN = 2'd1,
      PL_BLU = 2'd2
   } plane_e;

   localparam int N_PLANES = 3;

   // Flat table index of an entry
   function automatic int entry_index(input int ch, input int pl, input int val,
                                      input int span);
      return (ch * N_PLANES + pl) * span + val;
   endfunction
endpackage

// File: rtl/gamma_host_port.sv
module gamma_host_port #(
   parameter int AW    = 12,
   parameter int DW    = 8,
   parameter int DEPTH = 2304
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic          host_is_data,
   input  logic [AW:0]   host_wdata,
   input  logic          ram_off,
   output logic [AW-1:0] ptr_q,
   output logic          adv_q,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   initial begin
      if (DW > AW + 1) $error("gamma_host_port: entry wider than host word");
      if (DEPTH > (1 << AW)) $error("gamma_host_port: depth exceeds pointer range");
   end

   logic data_wr;
   assign data_wr = host_we & host_is_data;

   assign wr_en   = data_wr & ~ram_off & (ptr_q <= LAST);
   assign wr_addr = ptr_q;
   assign wr_data = host_wdata[DW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         adv_q <= 1'b0;
      end else if (host_we) begin
         if (!host_is_data) begin
            ptr_q <= host_wdata[AW-1:0];
            adv_q <= host_wdata[AW];
         end else if (adv_q) begin
            ptr_q <= (ptr_q >= LAST) ? '0 : ptr_q + AW'(1);
         end
      end
   end
endmodule

// File: rtl/gamma_table_ram.sv
module gamma_table_ram #(
   parameter int DW    = 8,
   parameter int AW    = 12,
   parameter int DEPTH = 2304,
   parameter int NRD   = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pwr_down,
   input  logic                   we,
   input  logic [AW-1:0]          waddr,
   input  logic [DW-1:0]          wdata,
   input  logic [NRD-1:0][AW-1:0] raddr,
   output logic [NRD-1:0][DW-1:0] rdata
);
   initial begin
      if (NRD < 1) $error("gamma_table_ram: needs a read port");
      if (DEPTH < 1) $error("gamma_table_ram: empty table");
   end

   logic [DW-1:0]    mem [DEPTH];
   logic [DEPTH-1:0] live;

   // Entry-valid flags model contents lost on power-down
   always_ff @(posedge clk) begin
      if (!rst_n || pwr_down) begin
         live <= '0;
      end else if (we && (int'(waddr) < DEPTH)) begin
         live[waddr] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (we && !pwr_down && (int'(waddr) < DEPTH)) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_comb begin
         rdata[p] = '0;
         if (int'(raddr[p]) < DEPTH) begin
            if (live[raddr[p]]) rdata[p] = mem[raddr[p]];
         end
      end
   end
endmodule

// File: rtl/gamma_pixel_stage.sv
module gamma_pixel_stage
   import gamma_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CHW    = 2,
   parameter int DW     = 8,
   parameter int AW     = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CH-1:0]           gam_en,
   input  logic                        pix_vld,
   input  logic [CHW-1:0]              pix_chan,
   input  logic [N_PLANES-1:0][DW-1:0] pix_in,
   output logic [N_PLANES-1:0][AW-1:0] rd_addr,
   input  logic [N_PLANES-1:0][DW-1:0] rd_data,
   output logic                        out_vld,
   output logic [N_PLANES-1:0][DW-1:0] out_px
);
   localparam int SPAN = 1 << DW;

   initial begin
      if ((1 << CHW) < NUM_CH) $error("gamma_pixel_stage: channel field too narrow");
      if (NUM_CH * N_PLANES * SPAN > (1 << AW)) $error("gamma_pixel_stage: address too narrow");
   end

   logic use_tbl;
   always_comb begin
      use_tbl = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (pix_chan == CHW'(c)) use_tbl = gam_en[c];
      end
   end

   for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
      always_comb begin
         rd_addr[p] = AW'(entry_index(int'(pix_chan), p, int'(pix_in[p]), SPAN));
      end

      always_ff @(posedge clk) begin
         if (!rst_n) out_px[p] <= '0;
         else if (pix_vld) out_px[p] <= use_tbl ? rd_data[p] : pix_in[p];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= pix_vld;
   end
endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank
   import gamma_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int DW     = 8,
   parameter int CHW    = 2,
   parameter int AW     = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_is_data,
   input  logic [AW:0]       host_wdata,
   output logic [AW-1:0]     tbl_addr,
   input  logic [NUM_CH-1:0] gam_en,
   input  logic              pix_vld,
   input  logic [CHW-1:0]    pix_chan,
   input  logic [DW-1:0]     pix_r,
   input  logic [DW-1:0]     pix_g,
   input  logic [DW-1:0]     pix_b,
   output logic              out_vld,
   output logic [DW-1:0]     out_r,
   output logic [DW-1:0]     out_g,
   output logic [DW-1:0]     out_b
);
   localparam int DEPTH = NUM_CH * N_PLANES * (1 << DW);

   initial begin
      if (NUM_CH < 1) $error("gamma_lut_bank: need at least one channel");
      if (DEPTH > (1 << AW)) $error("gamma_lut_bank: AW too small for table");
   end

   logic                        ram_off;
   logic                        adv_flag;
   logic                        wr_en;
   logic [AW-1:0]               wr_addr;
   logic [DW-1:0]               wr_data;
   logic [N_PLANES-1:0][AW-1:0] rd_addr;
   logic [N_PLANES-1:0][DW-1:0] rd_data;
   logic [N_PLANES-1:0][DW-1:0] px_in;
   logic [N_PLANES-1:0][DW-1:0] px_out;

   assign ram_off = ~|gam_en;

   gamma_host_port #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_host (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_is_data(host_is_data),
      .host_wdata(host_wdata), .ram_off(ram_off), .ptr_q(tbl_addr),
      .adv_q(adv_flag), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   gamma_table_ram #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .NRD(N_PLANES)) u_ram (
      .clk(clk), .rst_n(rst_n), .pwr_down(ram_off), .we(wr_en),
      .waddr(wr_addr), .wdata(wr_data), .raddr(rd_addr), .rdata(rd_data)
   );

   assign px_in[PL_RED] = pix_r;
   assign px_in[PL_GRN] = pix_g;
   assign px_in[PL_BLU] = pix_b;

   gamma_pixel_stage #(.NUM_CH(NUM_CH), .CHW(CHW), .DW(DW), .AW(AW)) u_pix (
      .clk(clk), .rst_n(rst_n), .gam_en(gam_en), .pix_vld(pix_vld),
      .pix_chan(pix_chan), .pix_in(px_in), .rd_addr(rd_addr),
      .rd_data(rd_data), .out_vld(out_vld), .out_px(px_out)
   );

   assign out_r = px_out[PL_RED];
   assign out_g = px_out[PL_GRN];
   assign out_b = px_out[PL_BLU];
endmodule

// File: rtl/gamma_lut_checker.sv
module gamma_lut_checker #(
   parameter int NUM_CH = 3,
   parameter int DW     = 8,
   parameter int CHW    = 2,
   parameter int AW     = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic              host_is_data,
   input logic [AW:0]       host_wdata,
   input logic [AW-1:0]     tbl_addr,
   input logic              adv_flag,
   input logic [NUM_CH-1:0] gam_en,
   input logic              pix_vld,
   input logic [CHW-1:0]    pix_chan,
   input logic [DW-1:0]     pix_r,
   input logic [DW-1:0]     pix_g,
   input logic [DW-1:0]     pix_b,
   input logic              out_vld,
   input logic [DW-1:0]     out_r,
   input logic [DW-1:0]     out_g,
   input logic [DW-1:0]     out_b
);
   localparam logic [AW-1:0] LAST = AW'(NUM_CH * 3 * (1 << DW) - 1);

   logic pass_now;
   always_comb begin
      pass_now = pix_vld;
      for (int c = 0; c < NUM_CH; c++) begin
         if (pix_chan == CHW'(c) && gam_en[c]) pass_now = 1'b0;
      end
   end

   logic data_adv;
   assign data_adv = host_we && host_is_data && adv_flag;

   a_r6_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld |=> out_vld);
   a_r6_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_vld |=> !out_vld);
   // R5 and R9: pass-through path
   a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      pass_now |=> (out_r == $past(pix_r) && out_g == $past(pix_g) && out_b == $past(pix_b)));
   a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && !host_is_data) |=> (tbl_addr == $past(host_wdata[AW-1:0]) && adv_flag == $past(host_wdata[AW])));
   a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (data_adv && tbl_addr < LAST) |=> tbl_addr == $past(tbl_addr) + AW'(1));
   a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (data_adv && tbl_addr == LAST) |=> tbl_addr == '0);
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_is_data && !adv_flag) |=> $stable(tbl_addr));
endmodule

bind gamma_lut_bank gamma_lut_checker #(
   .NUM_CH(NUM_CH), .DW(DW), .CHW(CHW), .AW(AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_is_data(host_is_data),
   .host_wdata(host_wdata), .tbl_addr(tbl_addr), .adv_flag(adv_flag),
   .gam_en(gam_en), .pix_vld(pix_vld), .pix_chan(pix_chan), .pix_r(pix_r),
   .pix_g(pix_g), .pix_b(pix_b), .out_vld(out_vld), .out_r(out_r),
   .out_g(out_g), .out_b(out_b)
);

// File: tb/sim_gamma_lut_bank.sv
`timescale 1ns/1ps
module sim_gamma_lut_bank;
   localparam int DEPTH = 2304;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic        host_is_data = 1'b0;
   logic [12:0] host_wdata = '0;
   logic [11:0] tbl_addr;
   logic [2:0]  gam_en = '0;
   logic        pix_vld = 1'b0;
   logic [1:0]  pix_chan = '0;
   logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
   logic        out_vld;
   logic [7:0]  out_r, out_g, out_b;

   int n_cmp = 0;
   int n_bad = 0;
   int mdl [DEPTH];
   int b_ptr = 0;
   bit b_adv = 0;

   always #4 clk = ~clk;

   gamma_lut_bank u0 (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_is_data(host_is_data),
      .host_wdata(host_wdata), .tbl_addr(tbl_addr), .gam_en(gam_en),
      .pix_vld(pix_vld), .pix_chan(pix_chan), .pix_r(pix_r), .pix_g(pix_g),
      .pix_b(pix_b), .out_vld(out_vld), .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   function automatic int pat(input int i);
      return (i * 37 + (i >> 8) * 11 + 5) & 255;
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic set_ptr(input int a, input bit adv);
      @(negedge clk);
      host_we = 1; host_is_data = 0; host_wdata = {adv, 12'(a)};
      @(negedge clk);
      host_we = 0;
      b_ptr = a; b_adv = adv;
   endtask

   task automatic put(input int d);
      @(negedge clk);
      host_we = 1; host_is_data = 1; host_wdata = 13'(d & 255);
      if (gam_en != 0 && b_ptr < DEPTH) mdl[b_ptr] = d & 255;
      if (b_adv) b_ptr = (b_ptr >= DEPTH - 1) ? 0 : b_ptr + 1;
      @(negedge clk);
      host_we = 0;
   endtask

   task automatic set_en(input logic [2:0] e);
      @(negedge clk);
      gam_en = e;
      if (e == 0) begin
         @(negedge clk);
         for (int i = 0; i < DEPTH; i++) mdl[i] = 0;
      end
   endtask

   task automatic px(input int ch, input int r, input int g, input int b, input string rq);
      int er, eg, eb;
      bit use_t;
      @(negedge clk);
      pix_vld = 1; pix_chan = 2'(ch); pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
      use_t = (ch < 3) && gam_en[ch];
      er = use_t ? mdl[ch*768 + r] : r;
      eg = use_t ? mdl[ch*768 + 256 + g] : g;
      eb = use_t ? mdl[ch*768 + 512 + b] : b;
      @(negedge clk);
      pix_vld = 0;
      chk(out_vld == 1'b1, {rq, " R6 vld"}, int'(out_vld), 1);
      chk(out_r == 8'(er) && out_g == 8'(eg) && out_b == 8'(eb), rq,
          int'({out_r, out_g, out_b}), (er << 16) | (eg << 8) | eb);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mdl[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk(out_vld == 0, "R10 out_vld", int'(out_vld), 0);
      chk(tbl_addr == 0, "R10 tbl_addr", int'(tbl_addr), 0);
      gam_en = 3'b111;
      px(1, 10, 20, 30, "R10 empty table");
      put(99); // flag clear after reset: pointer must stay
      chk(tbl_addr == 0, "R10 flag clear", int'(tbl_addr), 0);

      // R3 full load with auto-advance and wrap
      set_ptr(0, 1);
      for (int i = 0; i < DEPTH; i++) put(pat(i));
      chk(tbl_addr == 0, "R3 wrap", int'(tbl_addr), 0);

      // R1 sweep of every channel and value
      for (int ch = 0; ch < 3; ch++)
         for (int v = 0; v < 256; v++)
            px(ch, v, 255 - v, v ^ 8'h5A, "R1 lookup");

      // R2 / R4 pointer load and hold
      set_ptr(300, 0);
      chk(tbl_addr == 300, "R2 ptr load", int'(tbl_addr), 300);
      put(8'hA1);
      put(8'hB2);
      chk(tbl_addr == 300, "R4 ptr hold", int'(tbl_addr), 300);
      px(0, 1, 44, 2, "R4 overwrite");
      set_ptr(2303, 1);
      put(8'h3C);
      chk(tbl_addr == 0, "R3 wrap single", int'(tbl_addr), 0);
      px(2, 7, 8, 255, "R3 last entry");

      // R5 bypass on disabled channels
      set_en(3'b010);
      for (int v = 0; v < 256; v += 5) begin
         px(0, v, v ^ 8'hFF, (v * 3) & 255, "R5 bypass ch0");
         px(1, v, v ^ 8'hFF, (v * 3) & 255, "R5 mapped ch1");
         px(2, v, v ^ 8'hFF, (v * 3) & 255, "R5 bypass ch2");
      end

      // R9 out-of-range channel
      set_en(3'b111);
      px(3, 12, 34, 56, "R9 chan3");

      // R6 idle gives no valid
      @(negedge clk);
      chk(out_vld == 0, "R6 idle", int'(out_vld), 0);

      // R7 / R8 power-down loses contents and drops writes
      set_en(3'b000);
      set_ptr(0, 1);
      for (int i = 0; i < 5; i++) put(200 + i);
      chk(tbl_addr == 5, "R8 ptr advances", int'(tbl_addr), 5);
      set_en(3'b111);
      for (int v = 0; v < 5; v++) px(0, v, v, v, "R8 dropped write");
      for (int v = 0; v < 256; v += 17) px(1, v, v, v, "R7 stale zero");

      // R7 reload after power-up works
      set_ptr(768 + 9, 1);
      put(77);
      px(1, 9, 0, 0, "R7 reload");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule